// File: doc/BRIEF.md
# Store Queue with Age-Ordered Load Forwarding

This block holds in-flight stores in program order in a circular queue. A store takes an entry at the tail when it is dispatched. Its address and its data arrive later as two independent write operations, each aimed at the entry index handed out at allocation and each setting its own valid flag. When the oldest store retires, the head entry is presented on a data-cache write port and then released.

A load presents its address and its age position, which is the tail pointer value (wrap bit included) it saw when it was dispatched. The queue searches only the entries older than that position, over a wrapped range, and picks the youngest one whose address is valid and equal to the load address. If that store's data is valid, the load gets a hit and the data. If the data is not yet valid, the load is told to stall. The cache lookup runs in parallel outside this block. A flush moves the tail back to a given pointer and discards every entry from there to the old tail.

Occupancy is tracked by a three-state machine. SQ_EMPTY is the reset state. It goes to SQ_PARTIAL on allocation. SQ_PARTIAL goes to SQ_FULL when the occupancy reaches the depth, and back to SQ_EMPTY when the last entry retires or a flush empties the queue. SQ_FULL goes to SQ_PARTIAL on a retirement or a flush. The next state is always chosen from the next-cycle occupancy.

Top module: `stq_fwd`

## Requirements
- R1: After reset, q_empty is 1, q_full is 0, alloc_idx is 0, dc_wr_vld is 0, and no load hits or stalls.
- R2: alloc_idx always shows the tail entry index. Each accepted alloc_req advances it by one, modulo the depth of 8.
- R3: q_full is 1 once 8 entries are held. An alloc_req while full is ignored and the tail does not move.
- R4: When ret_req is high and the head entry has both a valid address and valid data, dc_wr_vld is 1 in the same cycle, dc_wr_addr and dc_wr_data carry the head entry's contents, and the head advances at the next clock edge.
- R5: A ret_req while the head entry lacks its address or its data produces no cache write and leaves the head in place.
- R6: Address writes (sta) and data writes (std) are independent. An entry with data but no valid address never matches a load.
- R7: Among the matching older stores, a load receives the data of the youngest one.
- R8: Stores at or after the load's position (ld_pos, a 4-bit pointer whose bit 3 is the wrap bit) are ignored, and so are stores when ld_vld is 0.
- R9: The search is correct when the older range wraps past entry 7 to entry 0.
- R10: If the youngest older matching store has no valid data, ld_stall is 1 and ld_hit is 0. An even older match with data is not used.
- R11: flush_vld sets the tail pointer to flush_tail and discards the entries from flush_tail up to the old tail. An alloc_req in the same cycle is ignored.
- R12: After every held entry has retired, q_empty returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocate one store entry at the tail |
| alloc_idx | output | 3 | Index of the tail entry |
| q_full | output | 1 | Queue holds 8 entries |
| q_empty | output | 1 | Queue holds no entries |
| sta_vld | input | 1 | Store-address write strobe |
| sta_idx | input | 3 | Entry index for the address write |
| sta_addr | input | 32 | Store address |
| std_vld | input | 1 | Store-data write strobe |
| std_idx | input | 3 | Entry index for the data write |
| std_data | input | 32 | Store data |
| ret_req | input | 1 | Retire the head store |
| dc_wr_vld | output | 1 | Cache write of the head store this cycle |
| dc_wr_addr | output | 32 | Cache write address |
| dc_wr_data | output | 32 | Cache write data |
| ld_vld | input | 1 | Load search request |
| ld_addr | input | 32 | Load address |
| ld_pos | input | 4 | Load age position (tail pointer at dispatch, wrap bit on top) |
| ld_hit | output | 1 | Forwarded data is valid |
| ld_stall | output | 1 | Youngest older match has no data yet |
| ld_data | output | 32 | Forwarded data |
| flush_vld | input | 1 | Roll the tail back |
| flush_tail | input | 4 | New tail pointer |

## Verification
Some properties are checked by assertions on every cycle. Hit and stall are never both raised. Full and empty are never both raised. The occupancy never exceeds the depth. A cache write only happens from a non-empty queue and always advances the head by one. Full holds unless a retirement or a flush happens. An empty queue never forwards or stalls. Other behaviour can only be shown by the bench scenarios: which of several matching stores is chosen, how the wrapped age range is cut, the stall-versus-hit choice, that a blocked retirement leaves the head in place, and which entries a flush drops. The bench checks these against hand-computed queue contents.

// File: rtl/stq_pkg.sv
package stq_pkg;
    typedef enum logic [1:0] {
        SQ_EMPTY   = 2'd0,
        SQ_PARTIAL = 2'd1,
        SQ_FULL    = 2'd2
    } occ_state_t;
endpackage

// File: rtl/stq_entry_array.sv
module stq_entry_array #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_we,
    input  logic [IW-1:0]        alloc_at,
    input  logic                 sta_we,
    input  logic [IW-1:0]        sta_at,
    input  logic [AW-1:0]        sta_val,
    input  logic                 std_we,
    input  logic [IW-1:0]        std_at,
    input  logic [DW-1:0]        std_val,
    input  logic                 rel_we,
    input  logic [IW-1:0]        rel_at,
    input  logic [DEPTH-1:0]     kill,
    output logic [DEPTH-1:0]     ent_live,
    output logic [DEPTH-1:0]     ent_av,
    output logic [DEPTH-1:0]     ent_dv,
    output logic [AW-1:0]        ent_addr [DEPTH],
    output logic [DW-1:0]        ent_data [DEPTH]
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic hit_alloc, hit_sta, hit_std, hit_rel;
        assign hit_alloc = alloc_we && (alloc_at == IW'(i));
        assign hit_sta   = sta_we   && (sta_at   == IW'(i));
        assign hit_std   = std_we   && (std_at   == IW'(i));
        assign hit_rel   = rel_we   && (rel_at   == IW'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_live[i] <= 1'b0;
                ent_av[i]   <= 1'b0;
                ent_dv[i]   <= 1'b0;
                ent_addr[i] <= '0;
                ent_data[i] <= '0;
            end else if (kill[i] || hit_rel) begin
                ent_live[i] <= 1'b0;
                ent_av[i]   <= 1'b0;
                ent_dv[i]   <= 1'b0;
            end else if (hit_alloc) begin
                ent_live[i] <= 1'b1;
                ent_av[i]   <= 1'b0;
                ent_dv[i]   <= 1'b0;
            end else begin
                if (hit_sta && ent_live[i]) begin
                    ent_av[i]   <= 1'b1;
                    ent_addr[i] <= sta_val;
                end
                if (hit_std && ent_live[i]) begin
                    ent_dv[i]   <= 1'b1;
                    ent_data[i] <= std_val;
                end
            end
        end
    end
endmodule

// File: rtl/stq_age_search.sv
module stq_age_search #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_vld,
    input  logic [AW-1:0]        ld_addr,
    input  logic [PW-1:0]        ld_pos,
    input  logic [PW-1:0]        head_ptr,
    input  logic [DEPTH-1:0]     ent_live,
    input  logic [DEPTH-1:0]     ent_av,
    input  logic [DEPTH-1:0]     ent_dv,
    input  logic [AW-1:0]        ent_addr [DEPTH],
    input  logic [DW-1:0]        ent_data [DEPTH],
    output logic                 fwd_hit,
    output logic                 fwd_stall,
    output logic [DW-1:0]        fwd_data
);
    logic [PW-1:0] older_raw, older_cnt;
    logic          found;
    logic [IW-1:0] pick;

    assign older_raw = ld_pos - head_ptr;
    assign older_cnt = (older_raw > PW'(DEPTH)) ? '0 : older_raw;

    // walk from the entry just before the load towards the head; first match wins
    always_comb begin
        logic [IW-1:0] slot;
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            slot = ld_pos[IW-1:0] - IW'(1) - IW'(k);
            if (!found && (PW'(k) < older_cnt) && ent_live[slot] &&
                ent_av[slot] && (ent_addr[slot] == ld_addr)) begin
                found = 1'b1;
                pick  = slot;
            end
        end
    end

    assign fwd_hit   = ld_vld && found && ent_dv[pick];
    assign fwd_stall = ld_vld && found && !ent_dv[pick];
    assign fwd_data  = fwd_hit ? ent_data[pick] : '0;

    AST_HIT_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_hit && fwd_stall)); // R10
    AST_IDLE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_vld |-> (!fwd_hit && !fwd_stall)); // R8
endmodule

// File: rtl/stq_fwd.sv
module stq_fwd #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_req,
    output logic [IW-1:0] alloc_idx,
    output logic          q_full,
    output logic          q_empty,
    input  logic          sta_vld,
    input  logic [IW-1:0] sta_idx,
    input  logic [AW-1:0] sta_addr,
    input  logic          std_vld,
    input  logic [IW-1:0] std_idx,
    input  logic [DW-1:0] std_data,
    input  logic          ret_req,
    output logic          dc_wr_vld,
    output logic [AW-1:0] dc_wr_addr,
    output logic [DW-1:0] dc_wr_data,
    input  logic          ld_vld,
    input  logic [AW-1:0] ld_addr,
    input  logic [PW-1:0] ld_pos,
    output logic          ld_hit,
    output logic          ld_stall,
    output logic [DW-1:0] ld_data,
    input  logic          flush_vld,
    input  logic [PW-1:0] flush_tail
);
    import stq_pkg::*;

    occ_state_t    state, state_nx;
    logic [PW-1:0] head_ptr, tail_ptr, head_nx, tail_nx, occ_nx, span;
    logic          alloc_fire, ret_fire;
    logic [DEPTH-1:0] kill, ent_live, ent_av, ent_dv;
    logic [AW-1:0] ent_addr [DEPTH];
    logic [DW-1:0] ent_data [DEPTH];
    logic [IW-1:0] head_idx;

    assign head_idx   = head_ptr[IW-1:0];
    assign alloc_idx  = tail_ptr[IW-1:0];
    assign alloc_fire = alloc_req && !q_full && !flush_vld;
    assign ret_fire   = ret_req && !q_empty && ent_av[head_idx] && ent_dv[head_idx];

    assign tail_nx = flush_vld ? flush_tail : tail_ptr + PW'(alloc_fire);
    assign head_nx = head_ptr + PW'(ret_fire);
    assign occ_nx  = tail_nx - head_nx;
    assign span    = tail_ptr - flush_tail;

    for (genvar i = 0; i < DEPTH; i++) begin : g_kill
        logic [IW-1:0] off;
        assign off     = IW'(i) - flush_tail[IW-1:0];
        assign kill[i] = flush_vld && ({1'b0, off} < span);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
            tail_ptr <= '0;
        end else begin
            head_ptr <= head_nx;
            tail_ptr <= tail_nx;
        end
    end

    // occupancy state machine: register process
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_EMPTY;
        else        state <= state_nx;
    end

    // next state from next-cycle occupancy
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_EMPTY:   if (occ_nx != '0) state_nx = (occ_nx == PW'(DEPTH)) ? SQ_FULL : SQ_PARTIAL;
            SQ_PARTIAL: if (occ_nx == '0) state_nx = SQ_EMPTY;
                        else if (occ_nx == PW'(DEPTH)) state_nx = SQ_FULL;
            SQ_FULL:    if (occ_nx != PW'(DEPTH)) state_nx = (occ_nx == '0) ? SQ_EMPTY : SQ_PARTIAL;
            default:    state_nx = SQ_EMPTY;
        endcase
    end

    // output process
    always_comb begin
        q_empty = 1'b0;
        q_full  = 1'b0;
        unique case (state)
            SQ_EMPTY:   q_empty = 1'b1;
            SQ_PARTIAL: ;
            SQ_FULL:    q_full = 1'b1;
            default:    q_empty = 1'b1;
        endcase
    end

    assign dc_wr_vld  = ret_fire;
    assign dc_wr_addr = ent_addr[head_idx];
    assign dc_wr_data = ent_data[head_idx];

    stq_entry_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_we (alloc_fire),
        .alloc_at (alloc_idx),
        .sta_we   (sta_vld),
        .sta_at   (sta_idx),
        .sta_val  (sta_addr),
        .std_we   (std_vld),
        .std_at   (std_idx),
        .std_val  (std_data),
        .rel_we   (ret_fire),
        .rel_at   (head_idx),
        .kill     (kill),
        .ent_live (ent_live),
        .ent_av   (ent_av),
        .ent_dv   (ent_dv),
        .ent_addr (ent_addr),
        .ent_data (ent_data)
    );

    stq_age_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_srch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_vld    (ld_vld),
        .ld_addr   (ld_addr),
        .ld_pos    (ld_pos),
        .head_ptr  (head_ptr),
        .ent_live  (ent_live),
        .ent_av    (ent_av),
        .ent_dv    (ent_dv),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .fwd_hit   (ld_hit),
        .fwd_stall (ld_stall),
        .fwd_data  (ld_data)
    );

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_ptr - head_ptr) <= PW'(DEPTH)); // R3
    AST_WR_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        dc_wr_vld |-> !q_empty); // R4
    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        dc_wr_vld |=> (head_ptr == PW'($past(head_ptr) + 1'b1))); // R4
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !ret_req && !flush_vld) |=> q_full); // R3
    AST_EMPTY_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> (!ld_hit && !ld_stall)); // R12
endmodule

// File: tb/sim_stq_fwd.sv
module sim_stq_fwd;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic [2:0]  alloc_idx;
    logic        q_full, q_empty;
    logic        sta_vld = 1'b0;
    logic [2:0]  sta_idx = '0;
    logic [31:0] sta_addr = '0;
    logic        std_vld = 1'b0;
    logic [2:0]  std_idx = '0;
    logic [31:0] std_data = '0;
    logic        ret_req = 1'b0;
    logic        dc_wr_vld;
    logic [31:0] dc_wr_addr, dc_wr_data;
    logic        ld_vld = 1'b0;
    logic [31:0] ld_addr = '0;
    logic [3:0]  ld_pos = '0;
    logic        ld_hit, ld_stall;
    logic [31:0] ld_data;
    logic        flush_vld = 1'b0;
    logic [3:0]  flush_tail = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stq_fwd u0 (.*);

    typedef struct packed {
        logic        vld;
        logic [3:0]  pos;
        logic [31:0] addr;
        logic        hit;
        logic        stall;
        logic [31:0] data;
    } ldvec_t;

    // queue: e0 0x100/A0, e1 0x200/B1, e2 0x100/C2, e3 0x100/no data, e4 data only
    localparam ldvec_t VT [9] = '{
        '{1'b1, 4'd5, 32'h100, 1'b0, 1'b1, 32'h0},   // R10 youngest older lacks data
        '{1'b1, 4'd3, 32'h100, 1'b1, 1'b0, 32'hC2},  // R7
        '{1'b1, 4'd2, 32'h100, 1'b1, 1'b0, 32'hA0},  // R8 younger e2 ignored
        '{1'b1, 4'd0, 32'h100, 1'b0, 1'b0, 32'h0},   // R8 nothing older
        '{1'b1, 4'd5, 32'h200, 1'b1, 1'b0, 32'hB1},  // R7
        '{1'b1, 4'd5, 32'h300, 1'b0, 1'b0, 32'h0},   // R7 no match
        '{1'b1, 4'd2, 32'h200, 1'b1, 1'b0, 32'hB1},  // R7
        '{1'b1, 4'd1, 32'h200, 1'b0, 1'b0, 32'h0},   // R8
        '{1'b0, 4'd5, 32'h100, 1'b0, 1'b0, 32'h0}    // R8 ld_vld low
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_alloc();
        alloc_req = 1'b1; tick(); alloc_req = 1'b0;
    endtask

    task automatic wr(input logic [2:0] idx, input logic av, input logic [31:0] a,
                      input logic dv, input logic [31:0] d);
        sta_vld = av; sta_idx = idx; sta_addr = a;
        std_vld = dv; std_idx = idx; std_data = d;
        tick();
        sta_vld = 1'b0; std_vld = 1'b0;
    endtask

    task automatic load(string req, input logic [3:0] pos, input logic [31:0] a,
                        input logic eh, input logic es, input logic [31:0] ed);
        ld_vld = 1'b1; ld_pos = pos; ld_addr = a;
        #1;
        check(req, {31'd0, ld_hit}, {31'd0, eh});
        check(req, {31'd0, ld_stall}, {31'd0, es});
        check(req, ld_data, ed);
        ld_vld = 1'b0;
    endtask

    task automatic retire(string req, input logic ev, input logic [31:0] ea, input logic [31:0] ed);
        ret_req = 1'b1;
        #1;
        check(req, {31'd0, dc_wr_vld}, {31'd0, ev});
        if (ev) begin
            check(req, dc_wr_addr, ea);
            check(req, dc_wr_data, ed);
        end
        tick();
        ret_req = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        check("R1 empty", {31'd0, q_empty}, 32'd1);
        check("R1 full", {31'd0, q_full}, 32'd0);
        check("R1 idx", {29'd0, alloc_idx}, 32'd0);
        check("R1 wr", {31'd0, dc_wr_vld}, 32'd0);
        load("R1 load", 4'd0, 32'h0, 1'b0, 1'b0, 32'h0);

        for (int i = 0; i < 5; i++) begin
            check("R2 alloc idx", {29'd0, alloc_idx}, i);
            do_alloc();
        end
        wr(3'd0, 1'b1, 32'h100, 1'b1, 32'hA0);
        wr(3'd1, 1'b1, 32'h200, 1'b1, 32'hB1);
        wr(3'd2, 1'b1, 32'h100, 1'b1, 32'hC2);
        wr(3'd3, 1'b1, 32'h100, 1'b0, 32'h0);
        wr(3'd4, 1'b0, 32'h0,   1'b1, 32'hE4);
        load("R6 data-only entry", 4'd5, 32'h0, 1'b0, 1'b0, 32'h0);

        for (int v = 0; v < 9; v++) begin
            ld_vld = VT[v].vld; ld_pos = VT[v].pos; ld_addr = VT[v].addr;
            #1;
            check("R7/R8/R10 table hit", {31'd0, ld_hit}, {31'd0, VT[v].hit});
            check("R7/R8/R10 table stall", {31'd0, ld_stall}, {31'd0, VT[v].stall});
            check("R7/R8/R10 table data", ld_data, VT[v].data);
        end
        ld_vld = 1'b0;

        wr(3'd4, 1'b1, 32'h100, 1'b0, 32'h0);
        load("R6 late address", 4'd5, 32'h100, 1'b1, 1'b0, 32'hE4);

        retire("R4 e0", 1'b1, 32'h100, 32'hA0);
        retire("R4 e1", 1'b1, 32'h200, 32'hB1);
        retire("R4 e2", 1'b1, 32'h100, 32'hC2);
        retire("R5 blocked", 1'b0, 32'h0, 32'h0);
        wr(3'd3, 1'b0, 32'h0, 1'b1, 32'hD3);
        retire("R5 head kept", 1'b1, 32'h100, 32'hD3);
        retire("R4 e4", 1'b1, 32'h100, 32'hE4);
        check("R12 empty", {31'd0, q_empty}, 32'd1);

        for (int i = 0; i < 8; i++) begin
            check("R2 wrap idx", {29'd0, alloc_idx}, (5 + i) % 8);
            do_alloc();
        end
        check("R3 full", {31'd0, q_full}, 32'd1);
        wr(3'd5, 1'b1, 32'h40,   1'b1, 32'h50);
        wr(3'd6, 1'b1, 32'h1006, 1'b1, 32'h66);
        wr(3'd7, 1'b1, 32'h40,   1'b1, 32'h57);
        wr(3'd0, 1'b1, 32'h40,   1'b1, 32'h60);
        wr(3'd1, 1'b1, 32'h1001, 1'b1, 32'h61);
        wr(3'd2, 1'b1, 32'h80,   1'b1, 32'h62);
        wr(3'd3, 1'b1, 32'h1003, 1'b1, 32'h63);
        wr(3'd4, 1'b1, 32'h1004, 1'b1, 32'h64);
        load("R9 wrapped youngest", 4'd13, 32'h40, 1'b1, 1'b0, 32'h60);
        load("R9 cut at idx0",      4'd8,  32'h40, 1'b1, 1'b0, 32'h57);
        load("R9 oldest only",      4'd6,  32'h40, 1'b1, 1'b0, 32'h50);
        load("R8 at head",          4'd5,  32'h40, 1'b0, 1'b0, 32'h0);
        load("R9 idx2",             4'd13, 32'h80, 1'b1, 1'b0, 32'h62);

        do_alloc();
        check("R3 still full", {31'd0, q_full}, 32'd1);
        retire("R4 wrap head", 1'b1, 32'h40, 32'h50);
        check("R3 not full", {31'd0, q_full}, 32'd0);
        check("R3 ignored alloc", {29'd0, alloc_idx}, 32'd5);
        do_alloc();
        check("R3 refull", {31'd0, q_full}, 32'd1);

        flush_vld = 1'b1; flush_tail = 4'd10; alloc_req = 1'b1;
        tick();
        flush_vld = 1'b0; alloc_req = 1'b0;
        check("R11 full", {31'd0, q_full}, 32'd0);
        check("R11 tail", {29'd0, alloc_idx}, 32'd2);
        load("R11 kept entries", 4'd10, 32'h40, 1'b1, 1'b0, 32'h60);
        retire("R11 drain1", 1'b1, 32'h1006, 32'h66);
        retire("R11 drain2", 1'b1, 32'h40, 32'h57);
        retire("R11 drain3", 1'b1, 32'h40, 32'h60);
        retire("R11 drain4", 1'b1, 32'h1001, 32'h61);
        check("R12 empty after drain", {31'd0, q_empty}, 32'd1);
        retire("R11 nothing left", 1'b0, 32'h0, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule